// File: doc/BRIEF.md
# Audio Master Frame and Bit Clock Generator

This block produces the frame clock and the bit clock of a serial audio port from the master clock. Two register fields set the division. A speed code picks a prescale of 1, 2, 4 or 8 master clocks for each internal step. A frame-length code picks 128, 125, 132 or 136 internal steps per frame. This gives 64, 62, 66 or 68 bit clocks per frame. An auto-detect enable freezes the settings already in effect. A master/slave select decides whether the two clocks are driven at all. Two informational flags, one for a 27 MHz master clock and one for the 8/16/32 kHz sample-rate group, are registered and reported only.

A prescaler turns the master clock into an internal step enable. A frame sequencer state machine runs on that enable. Its four states are `SEQ_IDLE`, `SEQ_HIGH`, `SEQ_LOW` and `SEQ_PAD`.

- **IDLE→HIGH**: on the first step while master mode is selected. This starts a frame.
- **HIGH→LOW**: on every step.
- **LOW→HIGH**: when the bit is not the last one in the frame, or when it is the last one and the frame length is even. In the second case this is a frame boundary.
- **LOW→PAD**: after the last bit of a 125-step frame.
- **PAD→HIGH**: always a frame boundary.
- **any→IDLE**: whenever slave mode is selected.

A settings holder copies the speed and frame-length fields into the active settings only at a frame boundary, or while idle.

Top module: `aud_sclk_gen`

## Requirements
- R1: While `rst_n` is low, `sclk_o`, `lrck_o`, `sclk_oe` and `lrck_oe` are 0. `speed_act` reads 2'b01, and `ratio_act`, `vid27_flag` and `grp32_flag` read 0.
- R2: In master mode, the first rising clock edge after reset release raises `sclk_o` and both enables, with `lrck_o` low.
- R3: Between consecutive rising edges of `lrck_o` there are N·2^S master clocks. S is the speed code (0..3), and N is 128, 125, 132 or 136 for frame-length codes 2'b00, 2'b01, 2'b10 and 2'b11.
- R4: Each frame holds exactly K rising edges of `sclk_o`, with K = 64, 62, 66 or 68 for frame-length codes 00, 01, 10 and 11.
- R5: Every high phase of `sclk_o` lasts 2^S master clocks, and `sclk_o` changes only on an internal step.
- R6: `lrck_o` is high for K/2 bit periods (K·2^S master clocks) per frame and changes only together with a falling edge of `sclk_o`.
- R7: A change of the speed or frame-length code mid-frame takes effect at the next frame boundary. Every high and low phase of `sclk_o` keeps either the old or the new width, and `speed_act`/`ratio_act` change only on a boundary.
- R8: While `auto_det_en` is 1, the speed and frame-length inputs are ignored. The active settings and the frame timing stay as they were.
- R9: In slave mode (`master_sel` = 0), from the next clock on both enables and both clock outputs are 0. The active settings follow the input codes as a record of the expected speed.
- R10: `vid27_flag` and `grp32_flag` show `vid27_sel` and `grp32_sel` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1 = generate clocks locally, 0 = slave |
| auto_det_en | input | 1 | 1 = freeze active settings |
| speed_sel | input | 2 | Speed code, prescale 2^code |
| ratio_sel | input | 2 | Frame-length code |
| vid27_sel | input | 1 | 27 MHz master clock flag |
| grp32_sel | input | 1 | 8/16/32 kHz group flag |
| sclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock |
| sclk_oe | output | 1 | Bit clock drive enable |
| lrck_oe | output | 1 | Frame clock drive enable |
| speed_act | output | 2 | Speed code in effect |
| ratio_act | output | 2 | Frame-length code in effect |
| vid27_flag | output | 1 | Stored 27 MHz flag |
| grp32_flag | output | 1 | Stored sample-group flag |

## Verification
A wrong prescaler count shows up within one bit period, as a high or low phase of the bit clock with the wrong width. A wrong bit counter or state in the sequencer shows up by the next frame clock rise, as a frame length or bit count off by at least one. Settings loaded outside a frame boundary show up within one bit period after the field change, as a phase width that belongs to neither the old nor the new speed.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;

    localparam int SPD_W = 2;
    localparam int RAT_W = 2;
    localparam int CYC_W = 8;
    localparam int BIT_W = CYC_W - 1;

    typedef logic [SPD_W-1:0] spd_code_t;
    typedef logic [RAT_W-1:0] rat_code_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HIGH = 2'd1,
        SEQ_LOW  = 2'd2,
        SEQ_PAD  = 2'd3
    } seq_state_e;

    localparam spd_code_t SPD_RESET = 2'b01;
    localparam rat_code_t RAT_RESET = 2'b00;

    // internal steps per frame for each frame-length code
    function automatic logic [CYC_W-1:0] frame_steps(input rat_code_t code);
        logic [CYC_W-1:0] n;
        unique case (code)
            2'b00:   n = 8'd128;
            2'b01:   n = 8'd125;
            2'b10:   n = 8'd132;
            default: n = 8'd136;
        endcase
        return n;
    endfunction

    function automatic logic [BIT_W-1:0] frame_bits(input rat_code_t code);
        logic [CYC_W-1:0] n;
        n = frame_steps(code);
        return n[CYC_W-1:1];
    endfunction

    function automatic logic frame_pad(input rat_code_t code);
        logic [CYC_W-1:0] n;
        n = frame_steps(code);
        return n[0];
    endfunction

endpackage

// File: rtl/aud_cfg_hold.sv
module aud_cfg_hold
    import aud_clkgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      auto_en,
    input  logic      load,
    input  spd_code_t speed_in,
    input  rat_code_t ratio_in,
    input  logic      vid_in,
    input  logic      grp_in,
    output spd_code_t speed_act,
    output rat_code_t ratio_act,
    output spd_code_t speed_nxt,
    output logic      vid_flag,
    output logic      grp_flag
);

    spd_code_t speed_q;
    rat_code_t ratio_q;
    rat_code_t ratio_nxt;

    // value taken at the next load; frozen while auto-detect is on
    always_comb begin
        speed_nxt = auto_en ? speed_q : speed_in;
        ratio_nxt = auto_en ? ratio_q : ratio_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed_q <= SPD_RESET;
            ratio_q <= RAT_RESET;
        end else if (load) begin
            speed_q <= speed_nxt;
            ratio_q <= ratio_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vid_flag <= 1'b0;
            grp_flag <= 1'b0;
        end else begin
            vid_flag <= vid_in;
            grp_flag <= grp_in;
        end
    end

    assign speed_act = speed_q;
    assign ratio_act = ratio_q;

endmodule

// File: rtl/aud_mclk_presc.sv
module aud_mclk_presc #(
    parameter int SPD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [SPD_W-1:0] speed_cur,
    input  logic [SPD_W-1:0] speed_new,
    output logic             tick
);

    localparam int CNT_W = (1 << SPD_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    function automatic logic [CNT_W-1:0] div_mask(input logic [SPD_W-1:0] s);
        return CNT_W'((1 << s) - 1);
    endfunction

    // the load step is itself count zero of the new prescale
    always_comb begin
        if (clr)
            cnt_d = '0;
        else if (load)
            cnt_d = CNT_W'(1) & div_mask(speed_new);
        else
            cnt_d = (cnt_q + 1'b1) & div_mask(speed_cur);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == '0);

endmodule

// File: rtl/aud_frame_seq.sv
module aud_frame_seq
    import aud_clkgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      master,
    input  logic      tick,
    input  rat_code_t ratio_act,
    output logic      sclk_o,
    output logic      lrck_o,
    output logic      drive_en,
    output logic      load
);

    seq_state_e       state_q, state_d;
    logic [BIT_W-1:0] bcnt_q, bcnt_d;
    logic [BIT_W-1:0] k_bits, half_bits;
    logic             pad_step, last_bit, frame_start;
    logic             sclk_q, lrck_q;

    always_comb begin
        k_bits    = frame_bits(ratio_act);
        half_bits = k_bits >> 1;
        pad_step  = frame_pad(ratio_act);
        last_bit  = (bcnt_q == k_bits - 1'b1);
    end

    // next state
    always_comb begin
        state_d     = state_q;
        bcnt_d      = bcnt_q;
        frame_start = 1'b0;
        if (!master) begin
            state_d = SEQ_IDLE;
            bcnt_d  = '0;
        end else if (tick) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    frame_start = 1'b1;
                    state_d     = SEQ_HIGH;
                    bcnt_d      = '0;
                end
                SEQ_HIGH: state_d = SEQ_LOW;
                SEQ_LOW: begin
                    if (!last_bit) begin
                        state_d = SEQ_HIGH;
                        bcnt_d  = bcnt_q + 1'b1;
                    end else if (pad_step) begin
                        state_d = SEQ_PAD;
                    end else begin
                        frame_start = 1'b1;
                        state_d     = SEQ_HIGH;
                        bcnt_d      = '0;
                    end
                end
                SEQ_PAD: begin
                    frame_start = 1'b1;
                    state_d     = SEQ_HIGH;
                    bcnt_d      = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            bcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            bcnt_q  <= bcnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            lrck_q <= 1'b0;
        end else if (!master) begin
            sclk_q <= 1'b0;
            lrck_q <= 1'b0;
        end else if (tick) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    sclk_q <= 1'b1;
                    lrck_q <= 1'b0;
                end
                SEQ_HIGH: begin
                    sclk_q <= 1'b0;
                    lrck_q <= (bcnt_q >= half_bits - 1'b1) && !last_bit;
                end
                SEQ_LOW:  sclk_q <= !(last_bit && pad_step);
                SEQ_PAD:  sclk_q <= 1'b1;
            endcase
        end
    end

    assign sclk_o   = sclk_q;
    assign lrck_o   = lrck_q;
    assign drive_en = (state_q != SEQ_IDLE);
    assign load     = frame_start || (!master && tick && state_q == SEQ_IDLE);

endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen
    import aud_clkgen_pkg::*;
(
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       master_sel,
    input  logic       auto_det_en,
    input  logic [1:0] speed_sel,
    input  logic [1:0] ratio_sel,
    input  logic       vid27_sel,
    input  logic       grp32_sel,
    output logic       sclk_o,
    output logic       lrck_o,
    output logic       sclk_oe,
    output logic       lrck_oe,
    output logic [1:0] speed_act,
    output logic [1:0] ratio_act,
    output logic       vid27_flag,
    output logic       grp32_flag
);

    logic      tick_w;
    logic      load_w;
    logic      drive_w;
    spd_code_t speed_nxt_w;

    aud_cfg_hold u_cfg (
        .clk       (mclk),
        .rst_n     (rst_n),
        .auto_en   (auto_det_en),
        .load      (load_w),
        .speed_in  (speed_sel),
        .ratio_in  (ratio_sel),
        .vid_in    (vid27_sel),
        .grp_in    (grp32_sel),
        .speed_act (speed_act),
        .ratio_act (ratio_act),
        .speed_nxt (speed_nxt_w),
        .vid_flag  (vid27_flag),
        .grp_flag  (grp32_flag)
    );

    aud_mclk_presc #(.SPD_W(SPD_W)) u_presc (
        .clk       (mclk),
        .rst_n     (rst_n),
        .clr       (!master_sel),
        .load      (load_w),
        .speed_cur (speed_act),
        .speed_new (speed_nxt_w),
        .tick      (tick_w)
    );

    aud_frame_seq u_seq (
        .clk       (mclk),
        .rst_n     (rst_n),
        .master    (master_sel),
        .tick      (tick_w),
        .ratio_act (ratio_act),
        .sclk_o    (sclk_o),
        .lrck_o    (lrck_o),
        .drive_en  (drive_w),
        .load      (load_w)
    );

    assign sclk_oe = drive_w;
    assign lrck_oe = drive_w;

endmodule

// File: rtl/aud_sclk_gen_chk.sv
module aud_sclk_gen_chk (
    input logic       mclk,
    input logic       rst_n,
    input logic       master_sel,
    input logic       auto_det_en,
    input logic       tick,
    input logic       load,
    input logic       sclk_o,
    input logic       lrck_o,
    input logic       sclk_oe,
    input logic       lrck_oe,
    input logic [1:0] speed_act,
    input logic [1:0] ratio_act
);

    assert_sclk_on_step_R5: assert property (@(posedge mclk) disable iff (!rst_n)
        (!$stable(sclk_o) && $past(master_sel)) |-> $past(tick));

    assert_lrck_on_fall_R6: assert property (@(posedge mclk) disable iff (!rst_n)
        (!$stable(lrck_o) && $past(master_sel)) |-> $fell(sclk_o));

    assert_cfg_only_at_boundary_R7: assert property (@(posedge mclk) disable iff (!rst_n)
        !load |=> ($stable(speed_act) && $stable(ratio_act)));

    assert_auto_freezes_R8: assert property (@(posedge mclk) disable iff (!rst_n)
        auto_det_en |=> ($stable(speed_act) && $stable(ratio_act)));

    assert_slave_quiet_R9: assert property (@(posedge mclk) disable iff (!rst_n)
        !master_sel |=> (!sclk_oe && !lrck_oe && !sclk_o && !lrck_o));

endmodule

bind aud_sclk_gen aud_sclk_gen_chk u_chk (
    .mclk        (mclk),
    .rst_n       (rst_n),
    .master_sel  (master_sel),
    .auto_det_en (auto_det_en),
    .tick        (tick_w),
    .load        (load_w),
    .sclk_o      (sclk_o),
    .lrck_o      (lrck_o),
    .sclk_oe     (sclk_oe),
    .lrck_oe     (lrck_oe),
    .speed_act   (speed_act),
    .ratio_act   (ratio_act)
);

// File: tb/aud_sclk_gen_tb_top.sv
module aud_sclk_gen_tb_top;

    localparam int MCLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 190000;

    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_sel = 1'b1;
    logic       auto_det_en = 1'b0;
    logic [1:0] speed_sel = 2'b00;
    logic [1:0] ratio_sel = 2'b00;
    logic       vid27_sel = 1'b0;
    logic       grp32_sel = 1'b0;
    logic       sclk_o, lrck_o, sclk_oe, lrck_oe;
    logic [1:0] speed_act, ratio_act;
    logic       vid27_flag, grp32_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(MCLK_PERIOD/2) mclk = ~mclk;

    aud_sclk_gen dut_i (
        .mclk(mclk), .rst_n(rst_n), .master_sel(master_sel), .auto_det_en(auto_det_en),
        .speed_sel(speed_sel), .ratio_sel(ratio_sel), .vid27_sel(vid27_sel), .grp32_sel(grp32_sel),
        .sclk_o(sclk_o), .lrck_o(lrck_o), .sclk_oe(sclk_oe), .lrck_oe(lrck_oe),
        .speed_act(speed_act), .ratio_act(ratio_act), .vid27_flag(vid27_flag), .grp32_flag(grp32_flag)
    );

    function automatic int exp_steps(input logic [1:0] r);
        case (r)
            2'b00: return 128;
            2'b01: return 125;
            2'b10: return 132;
            default: return 136;
        endcase
    endfunction

    function automatic int exp_bits(input logic [1:0] r);
        return exp_steps(r) / 2;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_lr_rise();
        logic p;
        p = lrck_o;
        forever begin
            @(negedge mclk);
            if (!p && lrck_o) break;
            p = lrck_o;
        end
    endtask

    task automatic measure(output int cyc, output int rises, output int lhi, output int shi);
        logic pl, ps;
        int run;
        wait_lr_rise();
        cyc = 0; rises = 0; lhi = 0; shi = 0; run = 0;
        forever begin
            cyc++;
            if (lrck_o) lhi++;
            if (sclk_o) run++;
            else begin
                if (run > 0) shi = run;
                run = 0;
            end
            pl = lrck_o;
            ps = sclk_o;
            @(negedge mclk);
            if (sclk_o && !ps) rises++;
            if (!pl && lrck_o) break;
        end
    endtask

    task automatic run_combo(input logic [1:0] s, input logic [1:0] r);
        int cyc, rises, lhi, shi;
        @(negedge mclk);
        speed_sel = s;
        ratio_sel = r;
        wait_lr_rise();
        wait_lr_rise();
        measure(cyc, rises, lhi, shi);
        check(cyc == (exp_steps(r) << s), "R3 mclk per frame", cyc, exp_steps(r) << s);
        check(rises == exp_bits(r), "R4 sclk per frame", rises, exp_bits(r));
        check(shi == (1 << s), "R5 sclk high width", shi, 1 << s);
        check(lhi == (exp_bits(r) << s), "R6 lrck high width", lhi, exp_bits(r) << s);
    endtask

    task automatic pulse_window(input int n, output int hmin, output int hmax,
                                output int lmin, output int lmax);
        int hr, lr, hseen, lseen;
        hr = 0; lr = 0; hseen = 0; lseen = 0;
        hmin = 99999; hmax = 0; lmin = 99999; lmax = 0;
        repeat (n) begin
            @(negedge mclk);
            if (sclk_o) begin
                if (lr > 0) begin
                    if (lseen > 0) begin
                        if (lr < lmin) lmin = lr;
                        if (lr > lmax) lmax = lr;
                    end
                    lseen++;
                end
                lr = 0;
                hr++;
            end else begin
                if (hr > 0) begin
                    if (hseen > 0) begin
                        if (hr < hmin) hmin = hr;
                        if (hr > hmax) hmax = hr;
                    end
                    hseen++;
                end
                hr = 0;
                lr++;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R1 reset state
        repeat (3) @(negedge mclk);
        check(!sclk_o && !lrck_o, "R1 clocks low in reset", {sclk_o, lrck_o}, 0);
        check(!sclk_oe && !lrck_oe, "R1 enables low in reset", {sclk_oe, lrck_oe}, 0);
        check(speed_act == 2'b01 && ratio_act == 2'b00, "R1 settings in reset",
              {speed_act, ratio_act}, 4'b0100);
        check(!vid27_flag && !grp32_flag, "R1 flags in reset", {vid27_flag, grp32_flag}, 0);

        // R2 first frame starts at the first edge after release
        rst_n = 1'b1;
        @(negedge mclk);
        check(sclk_o && !lrck_o && sclk_oe && lrck_oe, "R2 first step",
              {sclk_o, lrck_o, sclk_oe, lrck_oe}, 4'b1011);

        // all combinations
        for (int s = 0; s < 4; s++)
            for (int r = 0; r < 4; r++)
                run_combo(2'(s), 2'(r));

        // random combinations
        for (int i = 0; i < 6; i++)
            run_combo(2'($urandom_range(3, 0)), 2'($urandom_range(3, 0)));

        // R7 mid-frame change keeps whole phases
        begin
            int hmin, hmax, lmin, lmax;
            run_combo(2'b01, 2'b00);
            repeat ($urandom_range(90, 20)) @(negedge mclk);
            speed_sel = 2'b10;
            check(speed_act == 2'b01, "R7 setting held until boundary", speed_act, 1);
            pulse_window(1400, hmin, hmax, lmin, lmax);
            check(hmin >= 2 && hmax <= 4 && (hmin == 2 || hmin == 4) && (hmax == 2 || hmax == 4),
                  "R7 high phase widths", hmin * 100 + hmax, 204);
            check((lmin == 2 || lmin == 4) && (lmax == 2 || lmax == 4),
                  "R7 low phase widths", lmin * 100 + lmax, 204);
            check(speed_act == 2'b10, "R7 new setting after boundary", speed_act, 2);
        end

        // R8 auto-detect freezes settings
        begin
            int cyc, rises, lhi, shi;
            run_combo(2'b00, 2'b10);
            @(negedge mclk);
            auto_det_en = 1'b1;
            speed_sel = 2'b11;
            ratio_sel = 2'b01;
            wait_lr_rise();
            wait_lr_rise();
            measure(cyc, rises, lhi, shi);
            check(cyc == 132, "R8 frame unchanged under auto", cyc, 132);
            check(speed_act == 2'b00 && ratio_act == 2'b10, "R8 settings frozen",
                  {speed_act, ratio_act}, 4'b0010);
            @(negedge mclk);
            auto_det_en = 1'b0;
            wait_lr_rise();
            wait_lr_rise();
            measure(cyc, rises, lhi, shi);
            check(cyc == 1000, "R8 fields apply after auto off", cyc, 1000);
        end

        // R9 slave mode
        begin
            int bad;
            @(negedge mclk);
            master_sel = 1'b0;
            speed_sel = 2'b11;
            ratio_sel = 2'b10;
            bad = 0;
            repeat (200) begin
                @(negedge mclk);
                if (sclk_o || lrck_o || sclk_oe || lrck_oe) bad++;
            end
            check(bad == 0, "R9 slave outputs quiet", bad, 0);
            check(speed_act == 2'b11 && ratio_act == 2'b10, "R9 slave records fields",
                  {speed_act, ratio_act}, 4'b1110);
            speed_sel = 2'b00;
            ratio_sel = 2'b01;
            repeat (3) @(negedge mclk);
            check(speed_act == 2'b00 && ratio_act == 2'b01, "R9 slave follows fields",
                  {speed_act, ratio_act}, 4'b0001);
            master_sel = 1'b1;
            @(negedge mclk);
            check(sclk_o && sclk_oe, "R9 master restart", {sclk_o, sclk_oe}, 3);
            run_combo(2'b00, 2'b01);
        end

        // R10 flags
        for (int i = 0; i < 4; i++) begin
            logic v, g;
            v = 1'($urandom_range(1, 0));
            g = 1'(i);
            vid27_sel = v;
            grp32_sel = g;
            @(negedge mclk);
            check(vid27_flag == v && grp32_flag == g, "R10 flags reported",
                  {vid27_flag, grp32_flag}, {v, g});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge mclk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYC, 0);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule